// File: doc/BRIEF.md
# Interlocked Enhanced Parallel Port Host Cycle Engine

This block is the host side of an enhanced parallel port. A small register interface launches fully interlocked transfers on a shared 8-bit bus. There are four transfer types: address write, address read, data write and data read. The block drives a direction line, a data strobe and an address strobe. It drives the bus for writes and releases it for reads. Every strobe edge is paced by the peripheral's wait line.

A register access to offset 3 starts an address transfer and one to offset 4 starts a data transfer. A write access makes a write transfer and a read access makes a read transfer. The access stalls, with ready held low, until the transfer on the port has finished. Offsets 0 to 2 are local registers: a plain output latch with no strobe, a status view and a control register. The control register drives the peripheral reset line and gates the interrupt that comes back from the peripheral.

A stalled handshake is ended by a timeout counter, which also sets a sticky status flag. The bus is modelled as separate input, output and output-enable ports, so the tri-state buffer sits outside the block.

Top module: `epp_host_engine`

## Requirements
- R1: A write access to offset 3 runs an address write. `pp_astb_n` goes low while `pp_write_n` is low, `pp_bus_oe` is 1 and `pp_bus_out` carries the written byte. `pp_dstb_n` stays high.
- R2: A write access to offset 4 runs a data write in the same way, using `pp_dstb_n` in place of `pp_astb_n`. Whenever `pp_write_n` is low, the bus is driven.
- R3: A read access to offset 3 or 4 runs an address read or a data read. `pp_write_n` stays high and `pp_bus_oe` is 0 while the strobe is low. The byte on `pp_bus_in` when wait rises is returned on `reg_rdata`. At most one strobe is low at any time.
- R4: A strobe falls only after the wait line has been seen low. It rises only after the wait line has been seen high, unless a timeout ends the transfer.
- R5: A transfer that follows another does not assert its strobe until the peripheral has dropped wait low again, however long that takes.
- R6: `reg_ready` stays low until the parallel transfer has ended with both strobes high. It is then high for exactly one cycle.
- R7: If a transfer goes `TIMEOUT_CYC` cycles without completing its handshake, it is abandoned. Both strobes go high, the access completes, a read returns 8'hFF, and status bit 0 is set. The bit stays set until any write to offset 1 clears it.
- R8: A write to offset 0 stores a byte. That byte is driven on the bus (`pp_bus_oe`=1) whenever no transfer is active, and no strobe is generated. A read from offset 0 returns the byte.
- R9: Control offset 2: bit 0 set drives `pp_init_n` low. Bit 1 set makes `irq` follow the inverted, synchronized `pp_intr_n`. A read returns both bits.
- R10: A status read from offset 1 returns bit 0 = the timeout flag, bit 1 = the synchronized wait level and bit 2 = the synchronized interrupt level. All other bits read 0.
- R11: After reset both strobes, `pp_write_n` and `pp_init_n` are high, `reg_ready` and `irq` are 0, and the bus is driven with 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request, held until ready |
| reg_wr | input | 1 | 1 = write access, 0 = read access |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with ready |
| reg_ready | output | 1 | One-cycle completion of the access |
| pp_write_n | output | 1 | Direction line, low for write transfers |
| pp_dstb_n | output | 1 | Data strobe, active low |
| pp_astb_n | output | 1 | Address strobe, active low |
| pp_init_n | output | 1 | Peripheral reset, active low |
| pp_wait_n | input | 1 | Peripheral wait/handshake line |
| pp_intr_n | input | 1 | Peripheral interrupt, active low |
| pp_bus_in | input | 8 | Bus value seen at the pins |
| pp_bus_out | output | 8 | Value driven onto the bus |
| pp_bus_oe | output | 1 | Bus output enable |
| irq | output | 1 | Gated interrupt to the host |

## Verification
A corrupted transfer state shows up at the strobe pins within one or two cycles. The symptoms are a strobe that falls while wait is still high, a strobe that falls on the wrong line, or the bus staying enabled during a read. A lost completion shows at the register side instead: ready never rises, or rises while a strobe is still low. A broken timeout shows as a stall that lasts past `TIMEOUT_CYC` cycles, or as a status bit 0 that does not match the abandoned access. A wrong read latch shows on `reg_rdata` in the ready cycle of that access.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

  localparam int DATA_W = 8;

  localparam logic [2:0] OFF_LATCH = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_ADDR  = 3'd3;
  localparam logic [2:0] OFF_XFER  = 3'd4;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_SETUP,
    CYC_STROBE,
    CYC_DONE
  } cyc_state_e;

  typedef struct packed {
    logic is_addr;
    logic is_read;
  } cyc_kind_t;

  // Offsets 3 and 4 start a transfer on the port
  function automatic logic launches_cycle(logic [2:0] off);
    return (off == OFF_ADDR) || (off == OFF_XFER);
  endfunction

  function automatic cyc_kind_t decode_kind(logic [2:0] off, logic wr);
    cyc_kind_t k;
    k.is_addr = (off == OFF_ADDR);
    k.is_read = !wr;
    return k;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(logic tmo, logic wait_lvl,
                                                    logic intr_lvl);
    logic [DATA_W-1:0] v;
    v    = '0;
    v[0] = tmo;
    v[1] = wait_lvl;
    v[2] = intr_lvl;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(logic prst, logic ien);
    logic [DATA_W-1:0] v;
    v    = '0;
    v[0] = prst;
    v[1] = ien;
    return v;
  endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= RST_VAL;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/epp_timer.sv
module epp_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear)                 cnt <= '0;
    else if (run && cnt != LAST)    cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_host_pkg::*;
#(
  parameter int W           = 8,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  cyc_kind_t    kind,
  input  logic [W-1:0] wdata,
  input  logic         wait_s,
  input  logic [W-1:0] bus_in,
  output logic         write_n,
  output logic         dstb_n,
  output logic         astb_n,
  output logic         drive_en,
  output logic [W-1:0] drive_val,
  output logic         busy,
  output logic         done,
  output logic         timed_out,
  output logic [W-1:0] rd_data
);
  cyc_state_e   state;
  cyc_kind_t    kind_q;
  logic [W-1:0] wdata_q;
  logic [W-1:0] rd_q;
  logic         tmo_q;

  // Named handshake events
  logic hs_open;   // wait seen low in setup: strobe goes on
  logic hs_close;  // wait seen high with strobe on: strobe goes off
  logic tmo_hit;   // timer ran out before the handshake progressed
  logic tmr_run;
  logic tmr_exp;

  assign tmr_run  = (state == CYC_SETUP) || (state == CYC_STROBE);
  assign hs_open  = (state == CYC_SETUP)  && !wait_s;
  assign hs_close = (state == CYC_STROBE) &&  wait_s;
  assign tmo_hit  = tmr_exp && !hs_open && !hs_close;

  epp_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .run    (tmr_run),
    .expired(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CYC_IDLE;
      kind_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      tmo_q   <= 1'b0;
    end else begin
      unique case (state)
        CYC_IDLE: begin
          if (start) begin
            state   <= CYC_SETUP;
            kind_q  <= kind;
            wdata_q <= wdata;
            tmo_q   <= 1'b0;
          end
        end
        CYC_SETUP: begin
          if (hs_open) begin
            state <= CYC_STROBE;
          end else if (tmo_hit) begin
            state <= CYC_DONE;
            tmo_q <= 1'b1;
            rd_q  <= '1;
          end
        end
        CYC_STROBE: begin
          if (hs_close) begin
            state <= CYC_DONE;
            if (kind_q.is_read) rd_q <= bus_in;
          end else if (tmo_hit) begin
            state <= CYC_DONE;
            tmo_q <= 1'b1;
            rd_q  <= '1;
          end
        end
        CYC_DONE: state <= CYC_IDLE;
        default:  state <= CYC_IDLE;
      endcase
    end
  end

  logic strobe_on;
  assign strobe_on = (state == CYC_STROBE);
  assign dstb_n    = !(strobe_on && !kind_q.is_addr);
  assign astb_n    = !(strobe_on &&  kind_q.is_addr);
  assign write_n   = (state == CYC_IDLE) ? 1'b1 : kind_q.is_read;
  assign drive_en  = (state != CYC_IDLE) && !kind_q.is_read;
  assign drive_val = wdata_q;
  assign busy      = (state != CYC_IDLE);
  assign done      = (state == CYC_DONE);
  assign timed_out = tmo_q;
  assign rd_data   = rd_q;

  // R3: address and data strobes are never low together
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~dstb_n, ~astb_n}));

  // R4: a strobe falls only after wait was seen low
  assert_strobe_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dstb_n) || $fell(astb_n)) |-> $past(!wait_s));

  // R4, R7: a strobe rises only after wait was seen high, or on timeout
  assert_strobe_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dstb_n) || $rose(astb_n)) |-> ($past(wait_s) || $past(tmo_hit)));

  // R2: a low direction line always comes with a driven bus
  assert_write_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !write_n |-> drive_en);

  // R3: during a read strobe the bus is released
  assert_read_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dstb_n || !astb_n) && write_n) |-> !drive_en);

  // R7: timeout releases both strobes and completes
  assert_tmo_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (dstb_n && astb_n && done && timed_out));
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
  import epp_host_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_ready,
  output logic              pp_write_n,
  output logic              pp_dstb_n,
  output logic              pp_astb_n,
  output logic              pp_init_n,
  input  logic              pp_wait_n,
  input  logic              pp_intr_n,
  input  logic [DATA_W-1:0] pp_bus_in,
  output logic [DATA_W-1:0] pp_bus_out,
  output logic              pp_bus_oe,
  output logic              irq
);
  logic wait_s, intr_s;

  epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wait (
    .clk(clk), .rst_n(rst_n), .d(pp_wait_n), .q(wait_s));
  epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_intr (
    .clk(clk), .rst_n(rst_n), .d(pp_intr_n), .q(intr_s));

  logic              fsm_busy, fsm_done, fsm_tmo, fsm_drive;
  logic [DATA_W-1:0] fsm_val, fsm_rd;

  logic              ready_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] latch_q;
  logic              prst_q, ien_q, tmo_flag_q, pend_read_q;

  // Named acceptance events
  logic accept, launch, local_acc;
  assign accept    = reg_req && !fsm_busy && !ready_q;
  assign launch    = accept && launches_cycle(reg_addr);
  assign local_acc = accept && !launch;

  epp_cycle_fsm #(.W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .kind     (decode_kind(reg_addr, reg_wr)),
    .wdata    (reg_wdata),
    .wait_s   (wait_s),
    .bus_in   (pp_bus_in),
    .write_n  (pp_write_n),
    .dstb_n   (pp_dstb_n),
    .astb_n   (pp_astb_n),
    .drive_en (fsm_drive),
    .drive_val(fsm_val),
    .busy     (fsm_busy),
    .done     (fsm_done),
    .timed_out(fsm_tmo),
    .rd_data  (fsm_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rdata_q     <= '0;
      latch_q     <= '0;
      prst_q      <= 1'b0;
      ien_q       <= 1'b0;
      tmo_flag_q  <= 1'b0;
      pend_read_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (launch) begin
        pend_read_q <= !reg_wr;
      end else if (local_acc) begin
        ready_q <= 1'b1;
        rdata_q <= '0;
        unique case (reg_addr)
          OFF_LATCH: begin
            if (reg_wr) latch_q <= reg_wdata;
            else        rdata_q <= latch_q;
          end
          OFF_STAT: begin
            if (reg_wr) tmo_flag_q <= 1'b0;
            else        rdata_q <= pack_status(tmo_flag_q, wait_s, intr_s);
          end
          OFF_CTRL: begin
            if (reg_wr) begin
              prst_q <= reg_wdata[0];
              ien_q  <= reg_wdata[1];
            end else begin
              rdata_q <= pack_ctrl(prst_q, ien_q);
            end
          end
          default: rdata_q <= '0;
        endcase
      end else if (fsm_done) begin
        ready_q <= 1'b1;
        rdata_q <= pend_read_q ? fsm_rd : '0;
        if (fsm_tmo) tmo_flag_q <= 1'b1;
      end
    end
  end

  assign reg_ready  = ready_q;
  assign reg_rdata  = rdata_q;
  assign pp_init_n  = !prst_q;
  assign irq        = ien_q && !intr_s;
  assign pp_bus_oe  = fsm_busy ? fsm_drive : 1'b1;
  assign pp_bus_out = fsm_busy ? fsm_val   : latch_q;

  // R6: completion is a single-cycle pulse
  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ready |=> !reg_ready);

  // R6: completion never overlaps an active strobe
  assert_ready_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ready |-> (pp_dstb_n && pp_astb_n));

  // R8: outside a transfer the port drives the latch value
  assert_idle_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_write_n && pp_dstb_n && pp_astb_n && !fsm_busy) |-> pp_bus_oe);
endmodule

// File: tb/epp_host_engine_tb.sv
`timescale 1ns/1ps
module epp_host_engine_tb;
  localparam int TMO = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_req = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_ready;
  logic       pp_write_n, pp_dstb_n, pp_astb_n, pp_init_n;
  logic       wait_n = 1'b0;
  logic       intr_n = 1'b1;
  logic [7:0] bus_in = '0;
  logic [7:0] pp_bus_out;
  logic       pp_bus_oe, irq;

  always #4 clk = ~clk;

  epp_host_engine #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .pp_write_n(pp_write_n), .pp_dstb_n(pp_dstb_n),
    .pp_astb_n(pp_astb_n), .pp_init_n(pp_init_n), .pp_wait_n(wait_n),
    .pp_intr_n(intr_n), .pp_bus_in(bus_in), .pp_bus_out(pp_bus_out),
    .pp_bus_oe(pp_bus_oe), .irq(irq));

  int tests = 0, fails = 0;
  bit finished = 0;

  // Peripheral model: 0 normal, 1 wait stuck high, 2 wait stuck low
  int         pmode = 0;
  int         gap = 2;
  int         hcnt = 0;
  logic [7:0] periph_byte = 8'h00;
  logic [7:0] cap_byte = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      case (pmode)
        0: begin
          if ((!pp_dstb_n || !pp_astb_n) && !wait_n) begin
            if (hcnt >= 2) begin
              wait_n <= 1'b1; bus_in <= periph_byte; cap_byte <= pp_bus_out; hcnt <= 0;
            end else hcnt <= hcnt + 1;
          end else if (pp_dstb_n && pp_astb_n && wait_n) begin
            if (hcnt >= gap) begin wait_n <= 1'b0; hcnt <= 0; end
            else hcnt <= hcnt + 1;
          end else hcnt <= 0;
        end
        1: begin wait_n <= 1'b1; hcnt <= 0; end
        default: begin wait_n <= 1'b0; hcnt <= 0; end
      endcase
    end
  end

  // Strobe monitor
  logic prev_d = 1'b1, prev_a = 1'b1;
  int   fell_cnt = 0, r4_bad = 0;
  logic last_astb, last_wn, last_oe;
  logic [7:0] last_bus;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((prev_d && !pp_dstb_n) || (prev_a && !pp_astb_n)) begin
        fell_cnt++;
        last_astb = !pp_astb_n;
        last_wn   = pp_write_n;
        last_oe   = pp_bus_oe;
        last_bus  = pp_bus_out;
        if (wait_n) r4_bad++;
      end
      if (((!prev_d && pp_dstb_n) || (!prev_a && pp_astb_n)) && pmode == 0 && !wait_n)
        r4_bad++;
    end
    prev_d = pp_dstb_n;
    prev_a = pp_astb_n;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int ready_strobe_bad = 0, pulse_bad = 0;

  task automatic reg_access(input logic wr, input logic [2:0] a, input logic [7:0] wd,
                            output logic [7:0] rd, output int cyc);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (reg_ready || cyc > 2000) break;
    end
    rd = reg_rdata;
    if (!(pp_dstb_n && pp_astb_n)) ready_strobe_bad++;
    @(negedge clk); reg_req = 1'b0;
    @(posedge clk); #1;
    if (reg_ready) pulse_bad++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11", "dstb_n", pp_dstb_n, 1);
    chk("R11", "astb_n", pp_astb_n, 1);
    chk("R11", "write_n", pp_write_n, 1);
    chk("R11", "init_n", pp_init_n, 1);
    chk("R11", "ready", reg_ready, 0);
    chk("R11", "irq", irq, 0);
    chk("R11", "bus_oe", pp_bus_oe, 1);
    chk("R11", "bus_out", pp_bus_out, 8'h00);
  endtask

  task automatic t_addr_write;
    logic [7:0] rd; int cyc; int f0;
    f0 = fell_cnt;
    reg_access(1, 3'd3, 8'hA5, rd, cyc);
    chk("R1", "strobe count", fell_cnt - f0, 1);
    chk("R1", "address strobe used", last_astb, 1);
    chk("R1", "write_n at strobe", last_wn, 0);
    chk("R1", "bus driven", last_oe, 1);
    chk("R1", "bus value", last_bus, 8'hA5);
    chk("R1", "peripheral captured", cap_byte, 8'hA5);
  endtask

  task automatic t_data_write;
    logic [7:0] rd; int cyc; int f0;
    f0 = fell_cnt;
    reg_access(1, 3'd4, 8'h3C, rd, cyc);
    chk("R2", "strobe count", fell_cnt - f0, 1);
    chk("R2", "data strobe used", last_astb, 0);
    chk("R2", "write_n at strobe", last_wn, 0);
    chk("R2", "bus value", last_bus, 8'h3C);
    chk("R2", "peripheral captured", cap_byte, 8'h3C);
  endtask

  task automatic t_reads;
    logic [7:0] rd; int cyc;
    periph_byte = 8'hC3;
    reg_access(0, 3'd4, 8'h00, rd, cyc);
    chk("R3", "data read value", rd, 8'hC3);
    chk("R3", "data strobe used", last_astb, 0);
    chk("R3", "write_n high", last_wn, 1);
    chk("R3", "bus released", last_oe, 0);
    periph_byte = 8'h5E;
    reg_access(0, 3'd3, 8'h00, rd, cyc);
    chk("R3", "address read value", rd, 8'h5E);
    chk("R3", "address strobe used", last_astb, 1);
    chk("R3", "bus released", last_oe, 0);
  endtask

  task automatic t_back_to_back;
    logic [7:0] rd; int cyc; int f0;
    gap = 14;
    f0 = fell_cnt;
    reg_access(1, 3'd4, 8'h11, rd, cyc);
    reg_access(1, 3'd4, 8'h22, rd, cyc);
    chk("R5", "two strobes", fell_cnt - f0, 2);
    chk("R5", "second byte", cap_byte, 8'h22);
    chk("R5", "second waited for wait low (R4 violations)", r4_bad, 0);
    gap = 2;
  endtask

  task automatic t_ready_rules;
    chk("R6", "ready while strobe low", ready_strobe_bad, 0);
    chk("R6", "ready longer than one cycle", pulse_bad, 0);
    chk("R4", "strobe edge against wait", r4_bad, 0);
  endtask

  task automatic t_timeout;
    logic [7:0] rd; int cyc; int f0;
    pmode = 1; idle(6);
    f0 = fell_cnt;
    reg_access(1, 3'd4, 8'h77, rd, cyc);
    chk("R7", "no strobe while wait high", fell_cnt - f0, 0);
    chk("R7", "stall at least TIMEOUT", (cyc >= TMO), 1);
    chk("R7", "stall bounded", (cyc <= TMO + 8), 1);
    reg_access(0, 3'd1, 8'h00, rd, cyc);
    chk("R7", "sticky flag set", rd[0], 1);
    chk("R10", "wait level high", rd[1], 1);
    pmode = 2; idle(6);
    f0 = fell_cnt;
    reg_access(0, 3'd3, 8'h00, rd, cyc);
    chk("R7", "strobe was asserted", fell_cnt - f0, 1);
    chk("R7", "read returns FF", rd, 8'hFF);
    chk("R7", "strobes released", {pp_dstb_n, pp_astb_n}, 2'b11);
    reg_access(0, 3'd1, 8'h00, rd, cyc);
    chk("R7", "flag still set", rd[0], 1);
    chk("R10", "wait level low", rd[1], 0);
    reg_access(1, 3'd1, 8'h00, rd, cyc);
    reg_access(0, 3'd1, 8'h00, rd, cyc);
    chk("R7", "flag cleared", rd[0], 0);
    chk("R10", "upper bits zero", rd[7:3], 0);
    pmode = 0; idle(6);
  endtask

  task automatic t_latch;
    logic [7:0] rd; int cyc; int f0;
    f0 = fell_cnt;
    reg_access(1, 3'd0, 8'h5A, rd, cyc);
    idle(3);
    chk("R8", "no strobe", fell_cnt - f0, 0);
    chk("R8", "bus driven", pp_bus_oe, 1);
    chk("R8", "bus value", pp_bus_out, 8'h5A);
    reg_access(0, 3'd0, 8'h00, rd, cyc);
    chk("R8", "readback", rd, 8'h5A);
  endtask

  task automatic t_ctrl;
    logic [7:0] rd; int cyc;
    reg_access(1, 3'd2, 8'h01, rd, cyc);
    chk("R9", "init_n low", pp_init_n, 0);
    reg_access(1, 3'd2, 8'h02, rd, cyc);
    chk("R9", "init_n high", pp_init_n, 1);
    intr_n = 1'b0; idle(5);
    chk("R9", "irq on", irq, 1);
    reg_access(0, 3'd1, 8'h00, rd, cyc);
    chk("R10", "intr level low", rd[2], 0);
    intr_n = 1'b1; idle(5);
    chk("R9", "irq off", irq, 0);
    reg_access(0, 3'd2, 8'h00, rd, cyc);
    chk("R9", "ctrl readback", rd, 8'h02);
    intr_n = 1'b0;
    reg_access(1, 3'd2, 8'h00, rd, cyc);
    idle(5);
    chk("R9", "irq gated off", irq, 0);
    intr_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    idle(4);
    t_addr_write();
    t_data_write();
    t_reads();
    t_back_to_back();
    t_latch();
    t_ctrl();
    t_timeout();
    t_ready_rules();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule